// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block carries out the reset exception for a 68000-class processor core that sits on a 16-bit data bus. Reset is the highest-priority exception. Whatever the core was doing is abandoned without recovery, and the old program counter and status register are discarded rather than stacked. The block presents the core as supervisor-mode with the interrupt mask at 7, and it holds the core off (`core_hold`) until startup values are ready.

Once reset is released, the block selects the boot memory through its default chip-select and drives every other select inactive. It then reads four 16-bit words in supervisor program space from the boot base address. The first long word becomes the initial supervisor stack pointer and the second becomes the initial program counter. Each read waits for a data acknowledge. A read that is never acknowledged within a parameterised number of cycles sets a sticky error flag and starts the whole fetch again.

Top module: `boot_vec_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `bus_rd` is low and `bus_addr` equals `BOOT_BASE`. From the following cycle `bus_rd` is high and `bus_fc` is 3'b110 (supervisor program space).
- R2: `sup_state` is 1 and `int_mask` is 3'd7 both during the boot sequence and after it.
- R3: `cs_n` is active low. Bit `BOOT_CS` (default 0) is low and every other bit is high at all times, so the default value is 4'b1110.
- R4: A read keeps `bus_rd` high and `bus_addr` stable until `bus_ack` is sampled high. The four reads use the addresses `BOOT_BASE`+0, +2, +4 and +6, in that order.
- R5: Words are assembled high half first. Word 0 forms `init_ssp[31:16]`, word 1 forms `init_ssp[15:0]`, word 2 forms `init_pc[31:16]` and word 3 forms `init_pc[15:0]`.
- R6: `boot_ready` first rises in the cycle after the fourth word is acknowledged. In that same cycle `bus_rd` drops. Both stay in that state until the next reset, and `core_hold` is the inverse of `boot_ready`.
- R7: If `bus_rd` is held for `TIMEOUT_CYC` consecutive cycles (default 16) without an acknowledge, the next cycle has `bus_rd` low, `boot_err` high and `bus_addr` back at `BOOT_BASE`. The fetch then restarts from word 0.
- R8: `boot_err` stays high until reset, and a retry that completes still raises `boot_ready` with the retried words.
- R9: Asserting `rst_n` low at any step immediately, without waiting for a clock, clears `init_ssp`, `init_pc`, `boot_ready` and `boot_err`, drops `bus_rd` and returns `bus_addr` to `BOOT_BASE`.
- R10: `bus_ack` sampled while `bus_rd` is low (in the restart gap or after ready) changes neither `init_ssp` nor `init_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | ADDR_W | Byte address of the current boot read |
| bus_fc | output | 3 | Address space code, supervisor program |
| bus_rd | output | 1 | Read strobe |
| bus_ack | input | 1 | Data acknowledge from memory |
| bus_rdata | input | WORD_W | Read data word |
| cs_n | output | NUM_CS | Active-low chip-selects |
| init_ssp | output | 2*WORD_W | Assembled initial supervisor stack pointer |
| init_pc | output | 2*WORD_W | Assembled initial program counter |
| sup_state | output | 1 | Supervisor state flag presented to the core |
| int_mask | output | 3 | Interrupt priority mask presented to the core |
| core_hold | output | 1 | Holds the core until vectors are loaded |
| boot_ready | output | 1 | Vectors loaded, sticky until reset |
| boot_err | output | 1 | A read timed out at least once, sticky until reset |

## Verification
The bench inserts wait states of different lengths before individual acknowledges. A design that advanced the address early, or dropped the strobe early, would log the wrong word or mismatch the hold checks. It also stalls the bus after two good words and counts the strobe cycles up to the timeout. An off-by-one timer, or a restart that resumed at word 2 instead of word 0, would then show as a wrong count or a wrong address. Acknowledges are pulsed in the restart gap and after completion, which catches a design that captures data without a live strobe. Reset is pulled mid-fetch and with the error flag set, to expose state that is cleared only on a clock edge or not cleared at all.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    // Sequencer states: IDLE is both the post-reset state and the restart gap
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } seq_state_e;

    // Number of 16-bit words in the reset vector (SSP long word + PC long word)
    localparam int unsigned VEC_WORDS = 4;
    localparam int unsigned IDX_W     = $clog2(VEC_WORDS);

    // Address space code for supervisor program accesses
    localparam logic [2:0] FC_SUP_PROG = 3'b110;

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             err;
    } seq_regs_t;

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic expired
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = waiting && (cnt_q == CNT_W'(LIMIT - 1));
        if (!waiting || expired) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/boot_vec_regs.sv
module boot_vec_regs #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned NUM_WORDS = 4,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [NUM_WORDS*WORD_W-1:0] vec_flat
);
    logic [WORD_W-1:0] word_d [NUM_WORDS];
    logic [WORD_W-1:0] word_q [NUM_WORDS];

    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            word_d[i] = word_q[i];
        end
        if (wr_en) begin
            word_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                word_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                word_q[i] <= word_d[i];
            end
        end
    end

    // Word 0 lands in the most significant slot: high half first
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pack
        assign vec_flat[(NUM_WORDS-1-g)*WORD_W +: WORD_W] = word_q[g];
    end

endmodule

// File: rtl/boot_vec_seq.sv
module boot_vec_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 24,
    parameter int unsigned       WORD_W      = 16,
    parameter int unsigned       NUM_CS      = 4,
    parameter int unsigned       BOOT_CS     = 0,
    parameter int unsigned       TIMEOUT_CYC = 16,
    parameter logic [ADDR_W-1:0] BOOT_BASE   = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [2:0]          bus_fc,
    output logic                bus_rd,
    input  logic                bus_ack,
    input  logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_CS-1:0]   cs_n,
    output logic [2*WORD_W-1:0] init_ssp,
    output logic [2*WORD_W-1:0] init_pc,
    output logic                sup_state,
    output logic [2:0]          int_mask,
    output logic                core_hold,
    output logic                boot_ready,
    output logic                boot_err
);
    localparam int unsigned LONG_W   = 2 * WORD_W;
    localparam int unsigned STEP     = WORD_W / 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_WORDS - 1);

    seq_regs_t r_d, r_q;
    logic      waiting;
    logic      expired;
    logic      word_wr;
    logic [VEC_WORDS*WORD_W-1:0] vec_flat;

    boot_wait_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (waiting),
        .expired (expired)
    );

    boot_vec_regs #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (VEC_WORDS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (word_wr),
        .wr_idx   (r_q.idx),
        .wr_data  (bus_rdata),
        .vec_flat (vec_flat)
    );

    always_comb begin
        r_d     = r_q;
        word_wr = 1'b0;
        waiting = (r_q.state == ST_FETCH) && !bus_ack;
        case (r_q.state)
            ST_IDLE: begin
                r_d.state = ST_FETCH;
            end
            ST_FETCH: begin
                if (bus_ack) begin
                    word_wr = 1'b1;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else if (expired) begin
                    r_d.state = ST_IDLE;
                    r_d.idx   = '0;
                    r_d.err   = 1'b1;
                end
            end
            ST_DONE: begin
                r_d.state = ST_DONE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, idx: '0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // Boot select forced active, every other select parked inactive
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        if (g == BOOT_CS) begin : g_boot
            assign cs_n[g] = 1'b0;
        end else begin : g_other
            assign cs_n[g] = 1'b1;
        end
    end

    assign bus_addr   = BOOT_BASE + ADDR_W'(r_q.idx) * ADDR_W'(STEP);
    assign bus_fc     = FC_SUP_PROG;
    assign bus_rd     = (r_q.state == ST_FETCH);
    assign init_ssp   = vec_flat[2*LONG_W-1:LONG_W];
    assign init_pc    = vec_flat[LONG_W-1:0];
    assign sup_state  = 1'b1;
    assign int_mask   = 3'd7;
    assign boot_ready = (r_q.state == ST_DONE);
    assign core_hold  = (r_q.state != ST_DONE);
    assign boot_err   = r_q.err;

endmodule

// File: rtl/boot_vec_seq_chk.sv
module boot_vec_seq_chk #(
    parameter int unsigned       ADDR_W    = 24,
    parameter int unsigned       WORD_W    = 16,
    parameter int unsigned       NUM_CS    = 4,
    parameter int unsigned       BOOT_CS   = 0,
    parameter logic [ADDR_W-1:0] BOOT_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_ack,
    input logic [NUM_CS-1:0] cs_n,
    input logic              boot_ready,
    input logic              boot_err
);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(WORD_W / 8);
    localparam logic [ADDR_W-1:0] LAST_A = BOOT_BASE + ADDR_W'(3 * (WORD_W / 8));

    p_cs_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(~cs_n) && !cs_n[BOOT_CS]);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> (!bus_rd || $stable(bus_addr)));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ack && bus_addr != LAST_A) |=>
            (bus_rd && bus_addr == $past(bus_addr) + STEP_A));

    p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ready |=> boot_ready);

    p_ready_no_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ready |-> !bus_rd);

    p_ready_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_ready) |-> $past(bus_rd && bus_ack && bus_addr == LAST_A));

    p_err_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_err) |-> (!bus_rd && $past(bus_rd) && bus_addr == BOOT_BASE));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> boot_err);

endmodule

bind boot_vec_seq boot_vec_seq_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .NUM_CS    (NUM_CS),
    .BOOT_CS   (BOOT_CS),
    .BOOT_BASE (BOOT_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_ack    (bus_ack),
    .cs_n       (cs_n),
    .boot_ready (boot_ready),
    .boot_err   (boot_err)
);

// File: tb/boot_vec_seq_tb.sv
module boot_vec_seq_tb;
    localparam int unsigned ADDR_W  = 24;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned NUM_CS  = 4;
    localparam int unsigned TIMEOUT = 16;
    localparam logic [ADDR_W-1:0] BASE = '0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_ack = 1'b0;
    logic [WORD_W-1:0] bus_rdata = '0;
    logic [ADDR_W-1:0] bus_addr;
    logic [2:0]        bus_fc;
    logic              bus_rd;
    logic [NUM_CS-1:0] cs_n;
    logic [31:0]       init_ssp, init_pc;
    logic              sup_state, core_hold, boot_ready, boot_err;
    logic [2:0]        int_mask;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    boot_vec_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_fc     (bus_fc),
        .bus_rd     (bus_rd),
        .bus_ack    (bus_ack),
        .bus_rdata  (bus_rdata),
        .cs_n       (cs_n),
        .init_ssp   (init_ssp),
        .init_pc    (init_pc),
        .sup_state  (sup_state),
        .int_mask   (int_mask),
        .core_hold  (core_hold),
        .boot_ready (boot_ready),
        .boot_err   (boot_err)
    );

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Serve one read: hold for dly cycles, then acknowledge with data d
    task automatic serve_word(input logic [ADDR_W-1:0] a, input logic [15:0] d, input int dly);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk_eq("R4 strobe held", bus_rd, 1);
            chk_eq("R4 address held", bus_addr, a);
        end
        @(negedge clk);
        chk_eq("R4 strobe at ack", bus_rd, 1);
        chk_eq("R4 address order", bus_addr, a);
        bus_ack   = 1'b1;
        bus_rdata = d;
        @(negedge clk);
        bus_ack   = 1'b0;
        bus_rdata = 16'h5A5A;
    endtask

    task automatic t_reset_state();
        apply_reset();
        chk_eq("R1 no strobe after release", bus_rd, 0);
        chk_eq("R1 base address", bus_addr, BASE);
        chk_eq("R6 ready low", boot_ready, 0);
        chk_eq("R6 hold high", core_hold, 1);
        chk_eq("R8 err low", boot_err, 0);
        chk_eq("R2 supervisor", sup_state, 1);
        chk_eq("R2 mask", int_mask, 3'd7);
        chk_eq("R3 selects", cs_n, 4'b1110);
        @(negedge clk);
        chk_eq("R1 strobe on", bus_rd, 1);
        chk_eq("R1 space code", bus_fc, 3'b110);
        chk_eq("R1 base address", bus_addr, BASE);
    endtask

    task automatic t_zero_wait();
        apply_reset();
        serve_word(BASE + 0, 16'hA1B2, 0);
        serve_word(BASE + 2, 16'hC3D4, 0);
        serve_word(BASE + 4, 16'h0000, 0);
        serve_word(BASE + 6, 16'h1000, 0);
        chk_eq("R6 ready", boot_ready, 1);
        chk_eq("R6 strobe dropped", bus_rd, 0);
        chk_eq("R6 hold released", core_hold, 0);
        chk_eq("R5 ssp", init_ssp, 32'hA1B2C3D4);
        chk_eq("R5 pc", init_pc, 32'h00001000);
        chk_eq("R2 supervisor after", sup_state, 1);
        chk_eq("R2 mask after", int_mask, 3'd7);
        chk_eq("R3 selects after", cs_n, 4'b1110);
    endtask

    task automatic t_wait_states();
        apply_reset();
        serve_word(BASE + 0, 16'h0012, 3);
        serve_word(BASE + 2, 16'h3456, 0);
        serve_word(BASE + 4, 16'h789A, 5);
        chk_eq("R6 not ready after three", boot_ready, 0);
        serve_word(BASE + 6, 16'hBCDE, 1);
        chk_eq("R6 ready after four", boot_ready, 1);
        chk_eq("R5 ssp waits", init_ssp, 32'h00123456);
        chk_eq("R5 pc waits", init_pc, 32'h789ABCDE);
    endtask

    task automatic t_ack_ignored();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            bus_ack   = 1'b1;
            bus_rdata = 16'hFFFF;
        end
        @(negedge clk);
        bus_ack = 1'b0;
        @(negedge clk);
        chk_eq("R10 ssp unchanged", init_ssp, 32'h00123456);
        chk_eq("R10 pc unchanged", init_pc, 32'h789ABCDE);
        chk_eq("R6 ready sticky", boot_ready, 1);
        chk_eq("R6 no strobe", bus_rd, 0);
    endtask

    task automatic t_timeout();
        int n;
        apply_reset();
        serve_word(BASE + 0, 16'h1111, 0);
        serve_word(BASE + 2, 16'h2222, 0);
        n = 0;
        while (bus_rd && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk_eq("R7 strobe cycles before timeout", n, TIMEOUT);
        chk_eq("R7 err set", boot_err, 1);
        chk_eq("R7 gap strobe low", bus_rd, 0);
        chk_eq("R7 restart address", bus_addr, BASE);
        bus_ack   = 1'b1;
        bus_rdata = 16'hEEEE;
        @(negedge clk);
        bus_ack = 1'b0;
        chk_eq("R7 strobe again", bus_rd, 1);
        chk_eq("R7 word 0 again", bus_addr, BASE);
        serve_word(BASE + 0, 16'h8765, 0);
        serve_word(BASE + 2, 16'h4321, 2);
        serve_word(BASE + 4, 16'h0F0F, 0);
        serve_word(BASE + 6, 16'hF0F0, 0);
        chk_eq("R8 ready after retry", boot_ready, 1);
        chk_eq("R8 err sticky", boot_err, 1);
        chk_eq("R10 ssp ignores gap ack", init_ssp, 32'h87654321);
        chk_eq("R5 pc retry", init_pc, 32'h0F0FF0F0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_eq("R9 err cleared at once", boot_err, 0);
        chk_eq("R9 ready cleared at once", boot_ready, 0);
        chk_eq("R9 ssp cleared", init_ssp, 0);
        chk_eq("R9 pc cleared", init_pc, 0);
        @(negedge clk);
        rst_n = 1'b1;
        serve_word(BASE + 0, 16'hAAAA, 0);
        serve_word(BASE + 2, 16'hBBBB, 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_eq("R9 strobe dropped mid", bus_rd, 0);
        chk_eq("R9 address back mid", bus_addr, BASE);
        chk_eq("R9 ssp cleared mid", init_ssp, 0);
        @(negedge clk);
        rst_n = 1'b1;
        serve_word(BASE + 0, 16'h0102, 0);
        serve_word(BASE + 2, 16'h0304, 0);
        serve_word(BASE + 4, 16'h0506, 0);
        serve_word(BASE + 6, 16'h0708, 0);
        chk_eq("R9 ready after rerun", boot_ready, 1);
        chk_eq("R9 ssp after rerun", init_ssp, 32'h01020304);
        chk_eq("R9 pc after rerun", init_pc, 32'h05060708);
        chk_eq("R9 err stays clear", boot_err, 0);
    endtask

    initial begin
        t_reset_state();
        t_zero_wait();
        t_wait_states();
        t_ack_ignored();
        t_timeout();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule